// File: doc/BRIEF.md
# Register-Triggered External Memory Bridge

This block connects a host register port to a small external memory bus. The bus carries either a byte-wide Flash device or a word-wide SRAM. The host programs an address register and a control register. It then reads or writes a single data register, and each of those accesses runs one bus cycle. A mode bit in the control register chooses between the two devices. Flash cycles move only the low byte. SRAM cycles always move the whole 16-bit word. SRAM has no byte enables, so the host updates a single byte by reading the word, changing it and writing it back.

The host port uses a request/ready handshake. A data access that is allowed stalls the host with `hostReady` low while the bus cycle runs, so no request is lost. Access to the data register is allowed only when the stop flag is set or the SRAM size field is zero. In any other case the access completes at once and does nothing.

Top module: `extmem_bridge`

## Requirements
- R1: After reset, `busy` is 0, `memCsN`, `memOeN` and `memWeN` are all 1, and `hostReady` is 1 for any access except an allowed data access.
- R2: `hostSel` picks the register: 0 is data, 1 is address, 2 is control. Control bit 0 is the Flash mode bit, bit 1 is the stop flag, and bits 15:8 hold the SRAM size. The other control bits read as 0. Address and control writes complete in the cycle they are presented, and the same registers read back without delay.
- R3: With the mode bit at 1, a data read runs a Flash read cycle with `memCsN` and `memOeN` low and the address register on `memAddr`. The bus value `memDin[7:0]` is captured on the last clock of the cycle and returned on `hostRdata[7:0]`. The upper byte is unspecified.
- R4: With the mode bit at 1, a data write runs a Flash write cycle with `memWeN` low. `memDout[7:0]` carries the low write byte and `memDout[15:8]` is driven 0.
- R5: With the mode bit at 0, a data read runs an SRAM read cycle and returns the full 16-bit `memDin` word captured on the last clock.
- R6: With the mode bit at 0, a data write runs an SRAM write cycle that drives all 16 bits of the written word on `memDout`.
- R7: When the stop flag is 0 and the size field is nonzero, a data access completes with `hostReady` high at once and starts no bus cycle. A read in that case returns 0. When the size field is 0, data access is allowed even while the stop flag is 0.
- R8: In every bus cycle, `memCsN` and one of the two strobes stay low for exactly ACCESS_CYCLES clocks. Address and write data stay stable during that time, `memOeN` and `memWeN` are never low together, and `busy` stays high until the host handshake ends.
- R9: An allowed data access holds `hostReady` low for ACCESS_CYCLES+1 clocks. It then completes in the following cycle, and the request stays pending until then instead of being dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low hardware reset |
| hostReq | input | 1 | Host access request, held until accepted |
| hostWrite | input | 1 | 1 for a write, 0 for a read |
| hostSel | input | 2 | Register select: 0 data, 1 address, 2 control |
| hostWdata | input | 16 | Host write data |
| hostRdata | output | 16 | Host read data, valid while hostReady is high |
| hostReady | output | 1 | Access accepted at the next clock edge |
| busy | output | 1 | A bus cycle is running or completing |
| memCsN | output | 1 | Memory chip select, active low |
| memOeN | output | 1 | Memory output enable, active low |
| memWeN | output | 1 | Memory write enable, active low |
| memAddr | output | ADDR_W | Memory address |
| memDout | output | 16 | Write data to memory |
| memDoe | output | 1 | Write data drive enable |
| memDin | input | 16 | Read data from memory |

## Verification
A cycle counter that is off or a state that is held wrong shows up within one clock as a chip select or strobe that is too long or too short, or as `hostReady` rising early or late. A wrong captured word or byte lane shows up on `hostRdata` in the completion cycle of that same read. A wrong gating decision shows up at once, either as a bus cycle where none should run or as a stall where the host should get an immediate completion. Byte-lane faults in a Flash write appear on `memDout` while the write strobe is low.

// File: rtl/extmem_pkg.sv
package extmem_pkg;

  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam int SIZE_W = 8;

  localparam logic [1:0] SEL_DATA = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;

  localparam int CTRL_FLASH_BIT = 0;
  localparam int CTRL_STOP_BIT  = 1;
  localparam int CTRL_SIZE_LSB  = 8;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_FINISH = 2'd2
  } xferState_t;

  typedef struct packed {
    logic loadAddr;
    logic loadCtrl;
    logic loadData;
    logic capture;
    logic cycleOn;
    logic readCycle;
    logic flashCycle;
    logic returnData;
  } dpStrobe_t;

endpackage

// File: rtl/extmem_ctrl.sv
module extmem_ctrl
  import extmem_pkg::*;
#(
  parameter int ACCESS_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostReq,
  input  logic       hostWrite,
  input  logic [1:0] hostSel,
  input  logic       flashMode,
  input  logic       stopFlag,
  input  logic       sizeZero,
  output dpStrobe_t  strobe,
  output logic       hostReady,
  output logic       busy,
  output logic       memCsN,
  output logic       memOeN,
  output logic       memWeN
);

  localparam int CNT_W = (ACCESS_CYCLES > 1) ? $clog2(ACCESS_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(ACCESS_CYCLES - 1);

  xferState_t       state;
  logic [CNT_W-1:0] beatCnt;
  logic             cycRead;
  logic             cycFlash;

  logic dataHit, accessAllowed, launch, lastBeat, regWrite;

  assign dataHit       = hostReq && (hostSel == SEL_DATA);
  assign accessAllowed = stopFlag || sizeZero;
  assign launch        = (state == ST_IDLE) && dataHit && accessAllowed;
  assign lastBeat      = (state == ST_ACCESS) && (beatCnt == LAST_BEAT);
  assign regWrite      = (state == ST_IDLE) && hostReq && hostWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      beatCnt  <= '0;
      cycRead  <= 1'b0;
      cycFlash <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (launch) begin
            state    <= ST_ACCESS;
            beatCnt  <= '0;
            cycRead  <= !hostWrite;
            cycFlash <= flashMode;
          end
        end
        ST_ACCESS: begin
          if (lastBeat) begin
            state <= ST_FINISH;
          end else begin
            beatCnt <= beatCnt + 1'b1;
          end
        end
        ST_FINISH: begin
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.loadAddr   = regWrite && (hostSel == SEL_ADDR);
    strobe.loadCtrl   = regWrite && (hostSel == SEL_CTRL);
    strobe.loadData   = launch && hostWrite;
    strobe.capture    = lastBeat && cycRead;
    strobe.cycleOn    = (state == ST_ACCESS);
    strobe.readCycle  = cycRead;
    strobe.flashCycle = cycFlash;
    strobe.returnData = (state == ST_FINISH);
  end

  assign hostReady = ((state == ST_IDLE) && !launch) || (state == ST_FINISH);
  assign busy      = (state != ST_IDLE);
  assign memCsN    = !(state == ST_ACCESS);
  assign memOeN    = !((state == ST_ACCESS) && cycRead);
  assign memWeN    = !((state == ST_ACCESS) && !cycRead);

  // R9: host is stalled while the bus cycle runs
  a_r9_stall_in_access: assert property (@(posedge clk) disable iff (!rstN)
    !memCsN |-> !hostReady);

  // R9: completion lasts a single cycle
  a_r9_finish_single: assert property (@(posedge clk) disable iff (!rstN)
    (busy && hostReady) |=> !busy);

  // R8: strobes never overlap and only appear under chip select
  a_r8_strobe_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(!memOeN && !memWeN));

  a_r8_strobe_under_cs: assert property (@(posedge clk) disable iff (!rstN)
    (!memOeN || !memWeN) |-> !memCsN);

  // R8: the cycle type does not change while the strobe is active
  a_r8_kind_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!memCsN && $past(!memCsN)) |-> $stable(memOeN) && $stable(memWeN));

  // R7: a blocked data access starts nothing
  a_r7_blocked_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && dataHit && !accessAllowed) |=> (memCsN && !busy));

endmodule

// File: rtl/extmem_dpath.sv
module extmem_dpath
  import extmem_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [WORD_W-1:0] hostWdata,
  input  logic [1:0]        hostSel,
  input  logic [WORD_W-1:0] memDin,
  output logic [WORD_W-1:0] hostRdata,
  output logic              flashMode,
  output logic              stopFlag,
  output logic              sizeZero,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memDout,
  output logic              memDoe
);

  logic [ADDR_W-1:0] addrReg;
  logic [SIZE_W-1:0] sizeReg;
  logic              flashReg;
  logic              stopReg;
  logic [WORD_W-1:0] dataReg;
  logic [WORD_W-1:0] ctrlWord;
  logic              writeCycle;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg  <= '0;
      sizeReg  <= '0;
      flashReg <= 1'b0;
      stopReg  <= 1'b0;
    end else begin
      if (strobe.loadAddr) begin
        addrReg <= hostWdata[ADDR_W-1:0];
      end
      if (strobe.loadCtrl) begin
        flashReg <= hostWdata[CTRL_FLASH_BIT];
        stopReg  <= hostWdata[CTRL_STOP_BIT];
        sizeReg  <= hostWdata[CTRL_SIZE_LSB +: SIZE_W];
      end
    end
  end

  // Data holding register: no reset, contents undefined until first use
  always_ff @(posedge clk) begin
    if (strobe.loadData) begin
      dataReg <= hostWdata;
    end else if (strobe.capture) begin
      if (strobe.flashCycle) begin
        dataReg[BYTE_W-1:0] <= memDin[BYTE_W-1:0];
      end else begin
        dataReg <= memDin;
      end
    end
  end

  always_comb begin
    ctrlWord = '0;
    ctrlWord[CTRL_FLASH_BIT] = flashReg;
    ctrlWord[CTRL_STOP_BIT]  = stopReg;
    ctrlWord[CTRL_SIZE_LSB +: SIZE_W] = sizeReg;
  end

  always_comb begin
    unique case (hostSel)
      SEL_ADDR: hostRdata = WORD_W'(addrReg);
      SEL_CTRL: hostRdata = ctrlWord;
      SEL_DATA: hostRdata = strobe.returnData ? dataReg : '0;
      default:  hostRdata = '0;
    endcase
  end

  assign writeCycle = strobe.cycleOn && !strobe.readCycle;
  assign flashMode  = flashReg;
  assign stopFlag   = stopReg;
  assign sizeZero   = (sizeReg == '0);
  assign memAddr    = addrReg;
  assign memDoe     = writeCycle;

  always_comb begin
    memDout = '0;
    if (writeCycle) begin
      if (strobe.flashCycle) begin
        memDout[BYTE_W-1:0] = dataReg[BYTE_W-1:0];
      end else begin
        memDout = dataReg;
      end
    end
  end

  // R4: byte-wide writes leave the upper lane at zero
  a_r4_flash_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (memDoe && strobe.flashCycle) |-> (memDout[WORD_W-1:BYTE_W] == '0));

  // R8: address and write data hold still across the cycle
  a_r8_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cycleOn && $past(strobe.cycleOn)) |-> $stable(memAddr));

  a_r8_dout_stable: assert property (@(posedge clk) disable iff (!rstN)
    (memDoe && $past(memDoe)) |-> $stable(memDout));

endmodule

// File: rtl/extmem_bridge.sv
module extmem_bridge
  import extmem_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int ACCESS_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReq,
  input  logic              hostWrite,
  input  logic [1:0]        hostSel,
  input  logic [15:0]       hostWdata,
  output logic [15:0]       hostRdata,
  output logic              hostReady,
  output logic              busy,
  output logic              memCsN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [15:0]       memDout,
  output logic              memDoe,
  input  logic [15:0]       memDin
);

  dpStrobe_t strobe;
  logic      flashMode;
  logic      stopFlag;
  logic      sizeZero;

  extmem_ctrl #(
    .ACCESS_CYCLES(ACCESS_CYCLES)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .hostReq   (hostReq),
    .hostWrite (hostWrite),
    .hostSel   (hostSel),
    .flashMode (flashMode),
    .stopFlag  (stopFlag),
    .sizeZero  (sizeZero),
    .strobe    (strobe),
    .hostReady (hostReady),
    .busy      (busy),
    .memCsN    (memCsN),
    .memOeN    (memOeN),
    .memWeN    (memWeN)
  );

  extmem_dpath #(
    .ADDR_W(ADDR_W)
  ) uDpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .hostWdata (hostWdata),
    .hostSel   (hostSel),
    .memDin    (memDin),
    .hostRdata (hostRdata),
    .flashMode (flashMode),
    .stopFlag  (stopFlag),
    .sizeZero  (sizeZero),
    .memAddr   (memAddr),
    .memDout   (memDout),
    .memDoe    (memDoe)
  );

  // R1: no strobe while held in reset release idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (memCsN && memOeN && memWeN));

endmodule

// File: tb/sim_extmem_bridge.sv
`timescale 1ns/1ps
module sim_extmem_bridge;

  localparam int N  = 4;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          hostReq = 1'b0;
  logic          hostWrite = 1'b0;
  logic [1:0]    hostSel = 2'd0;
  logic [15:0]   hostWdata = 16'h0;
  logic [15:0]   hostRdata;
  logic          hostReady, busy, memCsN, memOeN, memWeN, memDoe;
  logic [AW-1:0] memAddr;
  logic [15:0]   memDout, memDin;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  extmem_bridge #(.ADDR_W(AW), .ACCESS_CYCLES(N)) u0 (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWrite(hostWrite),
    .hostSel(hostSel), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .hostReady(hostReady), .busy(busy), .memCsN(memCsN), .memOeN(memOeN),
    .memWeN(memWeN), .memAddr(memAddr), .memDout(memDout), .memDoe(memDoe),
    .memDin(memDin)
  );

  // external memory model
  logic [15:0] memArr [int];

  function automatic logic [15:0] memLook(input logic [AW-1:0] a);
    if (memArr.exists(int'(a))) return memArr[int'(a)];
    return 16'(int'(a) * 16'h0123) ^ 16'hC3A5;
  endfunction

  assign memDin = memOeN ? 16'h0000 : memLook(memAddr);

  always @(posedge clk) begin
    if (!memWeN) memArr[int'(memAddr)] = memDout;
  end

  task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int          mPhase = 0;
  bit          mRead, mFlash;
  logic [15:0] mAddr = 0, mCtrl = 0, mData = 0;
  int          csRun = 0;
  int          csStarts = 0;

  function automatic bit mAllowed();
    return mCtrl[1] || (mCtrl[15:8] == 8'h00);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; mAddr = 0; mCtrl = 0;
    end else if (mPhase == 0) begin
      if (hostReq && hostSel == 2'd0 && mAllowed()) begin
        mPhase = 1; mRead = !hostWrite; mFlash = mCtrl[0];
        if (hostWrite) mData = hostWdata;
      end else if (hostReq && hostWrite && hostSel == 2'd1) begin
        mAddr = hostWdata;
      end else if (hostReq && hostWrite && hostSel == 2'd2) begin
        mCtrl = hostWdata & 16'hFF03;
      end
    end else if (mPhase <= N) begin
      if (mPhase == N && mRead) begin
        if (mFlash) mData[7:0] = memDin[7:0];
        else mData = memDin;
      end
      mPhase++;
    end else begin
      mPhase = 0;
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    #2;
    if (rstN && !finished) begin
      bit act;
      bit expReady;
      act = (mPhase >= 1) && (mPhase <= N);
      expReady = (mPhase == 0 && !(hostReq && hostSel == 2'd0 && mAllowed())) || (mPhase == N + 1);
      cmp("R8 cs", memCsN, !act);
      cmp("R8 oe", memOeN, !(act && mRead));
      cmp("R8 we", memWeN, !(act && !mRead));
      cmp("R8 busy", busy, mPhase != 0);
      cmp("R9 ready", hostReady, expReady);
      if (act) begin
        cmp("R8 addr", memAddr, mAddr[AW-1:0]);
        if (!mRead) begin
          cmp("R4/R6 doe", memDoe, 1'b1);
          cmp(mFlash ? "R4 dout" : "R6 dout", memDout, mFlash ? {8'h00, mData[7:0]} : mData);
        end
      end
      if (hostReq && hostReady && !hostWrite) begin
        if (hostSel == 2'd1) cmp("R2 addr read", hostRdata, mAddr);
        else if (hostSel == 2'd2) cmp("R2 ctrl read", hostRdata, mCtrl);
        else if (mPhase == N + 1) begin
          if (mFlash) cmp("R3 rdata", hostRdata[7:0], mData[7:0]);
          else cmp("R5 rdata", hostRdata, mData);
        end else cmp("R7 blocked read", hostRdata, 16'h0);
      end
      if (!memCsN) begin
        if (csRun == 0) csStarts++;
        csRun++;
      end else if (csRun != 0) begin
        cmp("R8 cs length", csRun, N);
        csRun = 0;
      end
    end
  end

  task automatic hostDo(input logic wr, input logic [1:0] sel, input logic [15:0] wd,
                        output logic [15:0] rd, output int waits);
    @(negedge clk);
    hostReq = 1'b1; hostWrite = wr; hostSel = sel; hostWdata = wd; waits = 0;
    #1;
    while (!hostReady) begin
      @(negedge clk); #1; waits++;
    end
    rd = hostRdata;
    @(posedge clk); #1;
    hostReq = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    int waits;
    int startsBefore;
    repeat (3) @(negedge clk);
    #1;
    cmp("R1 busy", busy, 1'b0);
    cmp("R1 cs", memCsN, 1'b1);
    cmp("R1 oe", memOeN, 1'b1);
    cmp("R1 we", memWeN, 1'b1);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk); #1;
    cmp("R1 ready", hostReady, 1'b1);

    // R2 register programming and readback
    hostDo(1'b1, 2'd1, 16'h0012, rd, waits);
    cmp("R2 addr write no stall", waits, 0);
    hostDo(1'b1, 2'd2, 16'h10FE, rd, waits);
    hostDo(1'b0, 2'd2, 16'h0, rd, waits);
    cmp("R2 ctrl readback", rd, 16'h1002);
    hostDo(1'b0, 2'd1, 16'h0, rd, waits);
    cmp("R2 addr readback", rd, 16'h0012);

    // R6 SRAM write, then R5 SRAM read
    hostDo(1'b1, 2'd0, 16'hBEEF, rd, waits);
    cmp("R9 write stall", waits, N + 1);
    cmp("R6 memory word", memArr[32'h12], 16'hBEEF);
    hostDo(1'b0, 2'd0, 16'h0, rd, waits);
    cmp("R5 read word", rd, 16'hBEEF);
    cmp("R9 read stall", waits, N + 1);
    hostDo(1'b1, 2'd1, 16'h0077, rd, waits);
    hostDo(1'b0, 2'd0, 16'h0, rd, waits);
    cmp("R5 read preset", rd, memLook(16'h0077));

    // Flash mode
    hostDo(1'b1, 2'd2, 16'h1003, rd, waits);
    hostDo(1'b1, 2'd1, 16'h0040, rd, waits);
    hostDo(1'b0, 2'd0, 16'h0, rd, waits);
    cmp("R3 flash byte", rd[7:0], memLook(16'h0040) & 8'hFF);
    hostDo(1'b1, 2'd1, 16'h0050, rd, waits);
    hostDo(1'b1, 2'd0, 16'h12A5, rd, waits);
    cmp("R4 flash stored", memArr[32'h50], 16'h00A5);
    hostDo(1'b0, 2'd0, 16'h0, rd, waits);
    cmp("R3 flash readback", rd[7:0], 8'hA5);

    // R7 gating: stop=0, size nonzero
    hostDo(1'b1, 2'd2, 16'h1000, rd, waits);
    startsBefore = csStarts;
    hostDo(1'b1, 2'd0, 16'h5555, rd, waits);
    cmp("R7 write no stall", waits, 0);
    hostDo(1'b0, 2'd0, 16'h0, rd, waits);
    cmp("R7 read no stall", waits, 0);
    cmp("R7 read value", rd, 16'h0);
    repeat (3) @(negedge clk);
    cmp("R7 no bus cycle", csStarts - startsBefore, 0);
    cmp("R7 memory untouched", memArr[32'h50], 16'h00A5);

    // R7 size zero opens access with stop=0
    hostDo(1'b1, 2'd2, 16'h0000, rd, waits);
    hostDo(1'b1, 2'd0, 16'h3C3C, rd, waits);
    cmp("R7 size zero allows", waits, N + 1);
    cmp("R7 size zero write", memArr[32'h50], 16'h3C3C);

    // R9 back-to-back accesses: second request waits and completes
    hostDo(1'b0, 2'd0, 16'h0, rd, waits);
    cmp("R9 back to back read", rd, 16'h3C3C);
    hostDo(1'b1, 2'd1, 16'h0051, rd, waits);
    cmp("R9 addr after cycle", waits, 0);

    repeat (5) @(negedge clk);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule